// File: doc/BRIEF.md
# Endpoint Zero Control and Status Register

This block holds the eight-bit control/status word for the control endpoint of a USB device. It sits between a simple CPU register port (write strobe, write data, read data) and the event strobes of the USB protocol engine. Each bit follows its own rules for who may set it and who may clear it. Some bits are raised by the engine and dropped when the CPU writes one to a separate "serviced" position. One bit is raised by the CPU and only the engine can drop it. The stall request bit clears itself once the engine reports that the handshake has gone out.

The block also drives three outputs to the engine and the interrupt logic. A data-phase permit holds the engine out of the data stage until the CPU has taken the received setup. A stall request follows the force-stall bit. An interrupt flag records qualifying set and clear edges while an enable input is high, and stays high until an acknowledge input clears it. Packet storage, token decoding, CRC and the global interrupt register belong to other blocks.

Top module: `ep0_ctrl_status`

## Requirements
- R1: On a clock edge with `rst_n` low, every stored bit and the interrupt flag become zero, so `rd_data` reads 8'h00, `stall_req` and `irq` are low and `data_phase_ok` is high.
- R2: Bit 0 (OUT ready) is set on the edge after `ev_token`. A CPU write with data bit 6 (serviced OUT ready) set clears it. When both happen in the same cycle, the set wins.
- R3: `data_phase_ok` is low in every cycle in which bit 0 reads one, and high otherwise.
- R4: Bit 1 (IN ready) is set only by a CPU write with data bit 1 set. A write with data bit 1 clear leaves it unchanged. `ev_tx_ok` clears it.
- R5: Bit 2 (sent stall) is set on the edge after `ev_violation`. A CPU write with data bit 2 set clears it. When both happen in the same cycle, the set wins.
- R6: A CPU write with data bit 3 set raises bit 3 (force stall), and `stall_req` equals bit 3. `ev_stall_done` clears it.
- R7: Bit 4 (data end) is set by a CPU write with data bit 4 set, possibly in the same write that clears bit 0 through data bit 6. `ev_xfer_end` clears it.
- R8: Bit 5 (setup end) is set on the edge after `ev_early_end`. A CPU write with data bit 7 (serviced setup end) set clears it. When both happen in the same cycle, the set wins.
- R9: Bits 6 and 7 of `rd_data` always read zero, whatever value was written.
- R10: While `irq_en` is high, `irq` rises on the edge after any of these events: `ev_token`, `ev_tx_ok` while bit 1 is one, `ev_violation`, `ev_xfer_end` while bit 4 is one, or `ev_early_end`.
- R11: `irq` stays high until an edge where `irq_ack` is high and no enabled event occurs. Events that occur while `irq_en` is low never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | CPU write strobe for the register |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Current register value |
| ev_token | input | 1 | Engine: valid token received for endpoint zero |
| ev_tx_ok | input | 1 | Engine: IN packet transmitted successfully |
| ev_violation | input | 1 | Engine: protocol violation, STALL sent |
| ev_stall_done | input | 1 | Engine: forced STALL has been issued |
| ev_xfer_end | input | 1 | Engine: current setup transfer ended |
| ev_early_end | input | 1 | Engine: control transfer ended before data end was set |
| irq_en | input | 1 | Endpoint interrupt enable |
| irq_ack | input | 1 | Clears the interrupt flag |
| data_phase_ok | output | 1 | Engine may enter the data phase |
| stall_req | output | 1 | Request a STALL handshake |
| irq | output | 1 | Sticky endpoint interrupt request |

## Verification
The clear-on-write properties assume that the matching engine set event is not active in the same cycle. The interrupt acknowledge property assumes that `irq_en` is low while the acknowledge is applied. The stall release property assumes the CPU is not rewriting bit 3 in the cycle of `ev_stall_done`. The directed stimulus keeps to these conditions except in the tasks built to test collisions, and those tasks check the winning value at the ports rather than through the assertions.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;

    localparam int unsigned REG_W   = 8;
    localparam int unsigned N_IRQ   = 5;

    localparam int unsigned B_OPR   = 0;
    localparam int unsigned B_IPR   = 1;
    localparam int unsigned B_SST   = 2;
    localparam int unsigned B_FST   = 3;
    localparam int unsigned B_DEND  = 4;
    localparam int unsigned B_SEND  = 5;
    localparam int unsigned B_SVO   = 6;
    localparam int unsigned B_SVS   = 7;

    typedef struct packed {
        logic send;
        logic dend;
        logic fst;
        logic sst;
        logic ipr;
        logic opr;
    } ep0_bits_t;

    typedef struct packed {
        logic token;
        logic tx_ok;
        logic violation;
        logic stall_done;
        logic xfer_end;
        logic early_end;
    } ep0_evt_t;

endpackage

// File: rtl/ep0_csr_core.sv
module ep0_csr_core
    import ep0_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  ep0_evt_t         evt,
    output ep0_bits_t        bits_q,
    output logic [N_IRQ-1:0] irq_src
);

    ep0_bits_t bits_d;
    logic [REG_W-1:0] wr_one;
    logic unused_wr_bits;

    assign wr_one = wr_en ? wr_data : '0;
    assign unused_wr_bits = ^{wr_one[B_OPR], wr_one[B_SEND]};

    always_comb begin
        bits_d = bits_q;

        // OUT ready: engine set beats CPU service clear
        if (evt.token)
            bits_d.opr = 1'b1;
        else if (wr_one[B_SVO])
            bits_d.opr = 1'b0;

        // IN ready: CPU sets, only engine clears
        if (wr_one[B_IPR])
            bits_d.ipr = 1'b1;
        else if (evt.tx_ok)
            bits_d.ipr = 1'b0;

        // sent stall: engine set beats write-one clear
        if (evt.violation)
            bits_d.sst = 1'b1;
        else if (wr_one[B_SST])
            bits_d.sst = 1'b0;

        // force stall: released by the engine once issued
        if (wr_one[B_FST])
            bits_d.fst = 1'b1;
        else if (evt.stall_done)
            bits_d.fst = 1'b0;

        // data end: CPU sets, engine clears at transfer end
        if (wr_one[B_DEND])
            bits_d.dend = 1'b1;
        else if (evt.xfer_end)
            bits_d.dend = 1'b0;

        // setup end: engine set beats serviced clear
        if (evt.early_end)
            bits_d.send = 1'b1;
        else if (wr_one[B_SVS])
            bits_d.send = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bits_q <= '0;
        else
            bits_q <= bits_d;
    end

    assign irq_src = {evt.early_end,
                      evt.xfer_end & bits_q.dend,
                      evt.violation,
                      evt.tx_ok & bits_q.ipr,
                      evt.token};

endmodule

// File: rtl/ep0_irq_flag.sv
module ep0_irq_flag #(
    parameter int unsigned N_SRC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src,
    input  logic             en,
    input  logic             ack,
    output logic             flag_q
);

    logic flag_d;
    logic hit;

    assign hit = en & (|src);

    always_comb begin
        flag_d = flag_q;
        if (hit)
            flag_d = 1'b1;
        else if (ack)
            flag_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else
            flag_q <= flag_d;
    end

endmodule

// File: rtl/ep0_ctrl_status.sv
module ep0_ctrl_status
    import ep0_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             ev_token,
    input  logic             ev_tx_ok,
    input  logic             ev_violation,
    input  logic             ev_stall_done,
    input  logic             ev_xfer_end,
    input  logic             ev_early_end,
    input  logic             irq_en,
    input  logic             irq_ack,
    output logic             data_phase_ok,
    output logic             stall_req,
    output logic             irq
);

    ep0_evt_t         evt;
    ep0_bits_t        bits_q;
    logic [N_IRQ-1:0] irq_src;

    assign evt = '{token:      ev_token,
                   tx_ok:      ev_tx_ok,
                   violation:  ev_violation,
                   stall_done: ev_stall_done,
                   xfer_end:   ev_xfer_end,
                   early_end:  ev_early_end};

    ep0_csr_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .evt     (evt),
        .bits_q  (bits_q),
        .irq_src (irq_src)
    );

    ep0_irq_flag #(.N_SRC(N_IRQ)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (irq_src),
        .en     (irq_en),
        .ack    (irq_ack),
        .flag_q (irq)
    );

    assign rd_data       = {2'b00, bits_q};
    assign data_phase_ok = ~bits_q.opr;
    assign stall_req     = bits_q.fst;

endmodule

// File: rtl/ep0_ctrl_status_chk.sv
module ep0_ctrl_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       ev_token,
    input logic       ev_violation,
    input logic       ev_stall_done,
    input logic       ev_early_end,
    input logic       irq_en,
    input logic       irq_ack,
    input logic       data_phase_ok,
    input logic       stall_req,
    input logic       irq
);

    a_r2_token_sets_opr: assert property (@(posedge clk) disable iff (!rst_n)
        ev_token |=> rd_data[0]);

    a_r2_service_clears_opr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[6] && !ev_token) |=> !rd_data[0]);

    a_r3_no_data_phase: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] |-> !data_phase_ok);

    a_r4_ipr_cpu_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[1]) |-> $past(wr_en && wr_data[1]));

    a_r5_violation_sets_sst: assert property (@(posedge clk) disable iff (!rst_n)
        ev_violation |=> rd_data[2]);

    a_r6_stall_released: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stall_done && !(wr_en && wr_data[3])) |=> !stall_req);

    a_r8_early_sets_send: assert property (@(posedge clk) disable iff (!rst_n)
        ev_early_end |=> rd_data[5]);

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:6] == 2'b00);

    a_r11_no_irq_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_en));

    a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_en) |=> !irq);

endmodule

bind ep0_ctrl_status ep0_ctrl_status_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .ev_token      (ev_token),
    .ev_violation  (ev_violation),
    .ev_stall_done (ev_stall_done),
    .ev_early_end  (ev_early_end),
    .irq_en        (irq_en),
    .irq_ack       (irq_ack),
    .data_phase_ok (data_phase_ok),
    .stall_req     (stall_req),
    .irq           (irq)
);

// File: tb/ep0_ctrl_status_test.sv
`timescale 1ns/1ps
module ep0_ctrl_status_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ev_token = 1'b0, ev_tx_ok = 1'b0, ev_violation = 1'b0;
    logic       ev_stall_done = 1'b0, ev_xfer_end = 1'b0, ev_early_end = 1'b0;
    logic       irq_en = 1'b0, irq_ack = 1'b0;
    logic       data_phase_ok, stall_req, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ep0_ctrl_status uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ev_token(ev_token), .ev_tx_ok(ev_tx_ok), .ev_violation(ev_violation),
        .ev_stall_done(ev_stall_done), .ev_xfer_end(ev_xfer_end), .ev_early_end(ev_early_end),
        .irq_en(irq_en), .irq_ack(irq_ack),
        .data_phase_ok(data_phase_ok), .stall_req(stall_req), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock, returning 2 ns after the rising edge
    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic clear_in();
        wr_en = 0; wr_data = 0;
        ev_token = 0; ev_tx_ok = 0; ev_violation = 0;
        ev_stall_done = 0; ev_xfer_end = 0; ev_early_end = 0;
        irq_ack = 0;
    endtask

    task automatic cpu_wr(input logic [7:0] d);
        wr_en = 1; wr_data = d;
        cyc();
        clear_in();
    endtask

    task automatic do_reset();
        clear_in(); irq_en = 0;
        rst_n = 0; cyc(); cyc();
        rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reg", rd_data, 8'h00);
        check("R1 outs", {5'b0, data_phase_ok, stall_req, irq}, 8'h04);
    endtask

    task automatic t_opr();
        do_reset();
        ev_token = 1; cyc(); clear_in();
        check("R2 set", rd_data, 8'h01);
        check("R3 blocked", {7'b0, data_phase_ok}, 8'h00);
        cpu_wr(8'h40);
        check("R2 clear", rd_data, 8'h00);
        check("R3 permit", {7'b0, data_phase_ok}, 8'h01);
        ev_token = 1; wr_en = 1; wr_data = 8'h40; cyc(); clear_in();
        check("R2 set wins", rd_data, 8'h01);
        cpu_wr(8'h50);
        check("R7 dend with service", rd_data, 8'h10);
        ev_xfer_end = 1; cyc(); clear_in();
        check("R7 hw clear", rd_data, 8'h00);
    endtask

    task automatic t_ipr();
        do_reset();
        cpu_wr(8'h02);
        check("R4 cpu set", rd_data, 8'h02);
        cpu_wr(8'h00);
        check("R4 write zero ignored", rd_data, 8'h02);
        ev_tx_ok = 1; cyc(); clear_in();
        check("R4 hw clear", rd_data, 8'h00);
    endtask

    task automatic t_stall();
        do_reset();
        ev_violation = 1; cyc(); clear_in();
        check("R5 set", rd_data, 8'h04);
        ev_violation = 1; wr_en = 1; wr_data = 8'h04; cyc(); clear_in();
        check("R5 set wins", rd_data, 8'h04);
        cpu_wr(8'h04);
        check("R5 clear", rd_data, 8'h00);
        cpu_wr(8'h08);
        check("R6 force", {rd_data[3], stall_req}, 2'b11);
        cyc();
        check("R6 holds", {rd_data[3], stall_req}, 2'b11);
        ev_stall_done = 1; cyc(); clear_in();
        check("R6 self clear", {rd_data[3], stall_req}, 2'b00);
    endtask

    task automatic t_setup_end();
        do_reset();
        ev_early_end = 1; cyc(); clear_in();
        check("R8 set", rd_data, 8'h20);
        cpu_wr(8'h20);
        check("R8 bit5 write no clear", rd_data, 8'h20);
        ev_early_end = 1; wr_en = 1; wr_data = 8'h80; cyc(); clear_in();
        check("R8 set wins", rd_data, 8'h20);
        cpu_wr(8'h80);
        check("R8 clear", rd_data, 8'h00);
        cpu_wr(8'hC0);
        check("R9 reserved", rd_data, 8'h00);
    endtask

    task automatic t_irq();
        do_reset();
        ev_token = 1; cyc(); clear_in();
        check("R11 disabled event", {7'b0, irq}, 8'h00);
        irq_en = 1;
        ev_violation = 1; cyc(); clear_in();
        check("R10 violation irq", {7'b0, irq}, 8'h01);
        cyc();
        check("R11 sticky", {7'b0, irq}, 8'h01);
        irq_en = 0; irq_ack = 1; cyc(); clear_in();
        check("R11 ack", {7'b0, irq}, 8'h00);
        irq_en = 1;
        ev_xfer_end = 1; cyc(); clear_in();
        check("R10 xfer end with dend zero", {7'b0, irq}, 8'h00);
        cpu_wr(8'h12);
        check("R10 cpu writes no irq", {7'b0, irq}, 8'h00);
        ev_tx_ok = 1; cyc(); clear_in();
        check("R10 ipr clear irq", {7'b0, irq}, 8'h01);
        irq_ack = 1; ev_xfer_end = 1; cyc(); clear_in();
        check("R11 event beats ack", {7'b0, irq}, 8'h01);
        irq_ack = 1; cyc(); clear_in();
        check("R11 ack enabled", {7'b0, irq}, 8'h00);
        ev_early_end = 1; cyc(); clear_in();
        check("R10 setup end irq", {7'b0, irq}, 8'h01);
        irq_ack = 1; cyc(); clear_in();
        ev_token = 1; cyc(); clear_in();
        check("R10 token irq", {7'b0, irq}, 8'h01);
    endtask

    initial begin
        t_reset();
        t_opr();
        t_ipr();
        t_stall();
        t_setup_end();
        t_irq();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule